// File: doc/BRIEF.md
# Serial Flash Read Instruction Sequencer

This block converts a memory-mapped flash read request into an ordered list of micro-operations for a lower-level serial shifter. A requester hands over a start address with a valid/ready handshake. The sequencer then walks a programmable instruction descriptor. An optional command byte goes out first, followed by a configurable number of address bytes and an optional dummy phase that drives a pad pattern. A final receive operation reads one data byte. Each phase has its own lane width: single, dual or quad.

Every micro-operation carries a frame byte, a one-hot lane select, a bit or cycle count, a direction flag and a flag that suppresses the data-line output enables. It is offered to the shifter over a valid/ready link. The shifter returns the received byte on a strobe. The sequencer holds that byte for the requester until it is taken. Chip select frames the whole instruction and is released before the next request is accepted. The descriptor is captured when the request is accepted, so software may rewrite it while a sequence is running.

Top module: `flash_seq`

## Requirements
- R1: `req_ready_o` is high only while `en_i` is high and no sequence is in progress. A request offered while `en_i` is low is not accepted and produces no micro-operation.
- R2: A lane-mode field is 2 bits wide. It maps to `uop_lane_o` as follows: 0 (single) gives 3'b001, 1 (dual) gives 3'b010, 2 (quad) gives 3'b100, and the reserved value 3 gives 3'b001. Exactly one bit is always set.
- R3: When `cmd_en_i` is set, the first micro-operation carries `cmd_code_i`, the command lane mode, a count of 8, and transmit direction (`uop_rx_o`=0). When `cmd_en_i` is clear, no command operation is issued.
- R4: The address phase issues one 8-bit transmit operation per address byte, using the address lane mode. Bytes go out most-significant first, taken from the low `addr_bytes_i` bytes of the request address. A byte count above AW/8 is clamped to AW/8, and a count of 0 skips the phase.
- R5: When `pad_cnt_i` is nonzero, the sequencer issues one transmit operation with frame `pad_code_i`, count `pad_cnt_i` and the data lane mode. When it is zero, the dummy phase is skipped.
- R6: `uop_oe_off_o` is set on the dummy operation exactly when `dummy_oe_off_i` was set, and it is clear on every other operation.
- R7: The last operation of every request is a receive (`uop_rx_o`=1) with count 8, frame 0 and the data lane mode. No further operation is issued for that request.
- R8: `cs_o` is high on every cycle an operation is offered. It stays high from the first operation until the received byte arrives, and it is low while that byte waits to be taken. It is therefore low for at least one cycle between requests.
- R9: The received byte is offered on `data_o`/`data_valid_o` and held stable until `data_ready_i` is high. No operation is offered while it waits.
- R10: While `uop_valid_o` is high and `uop_ready_i` is low, every micro-operation output stays unchanged.
- R11: Descriptor inputs changed after a request is accepted have no effect on that request's operations.
- R12: A strobe on `rx_valid_i` while the sequencer is not waiting for received data is ignored, and `data_valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables acceptance of new requests |
| cmd_en_i | input | 1 | Issue the command byte |
| cmd_code_i | input | 8 | Command byte value |
| cmd_mode_i | input | 2 | Command lane mode |
| addr_bytes_i | input | ABW | Address byte count |
| addr_mode_i | input | 2 | Address lane mode |
| pad_code_i | input | 8 | Pattern driven during the dummy phase |
| pad_cnt_i | input | PAD_W | Dummy cycle count |
| data_mode_i | input | 2 | Dummy and data lane mode |
| dummy_oe_off_i | input | 1 | Suppress output enables during the dummy phase |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted |
| req_addr_i | input | AW | Request address |
| uop_valid_o | output | 1 | Micro-operation offered |
| uop_ready_i | input | 1 | Shifter takes the micro-operation |
| uop_frame_o | output | 8 | Frame byte |
| uop_lane_o | output | 3 | One-hot lane select |
| uop_cnt_o | output | CNT_W | Bit or cycle count |
| uop_rx_o | output | 1 | 1 = receive, 0 = transmit |
| uop_oe_off_o | output | 1 | Suppress data-line output enables |
| cs_o | output | 1 | Chip select, active high |
| rx_valid_i | input | 1 | Received byte strobe from the shifter |
| rx_frame_i | input | 8 | Received byte |
| data_valid_o | output | 1 | Received byte offered |
| data_ready_i | input | 1 | Requester takes the byte |
| data_o | output | 8 | Received byte |

## Verification
The bench first targets phase skipping: no command, zero address bytes and zero pad cycles. A sequencer that got this wrong would emit empty operations or lose the receive step. Address byte order and clamping come next. A reversed or unclamped counter would put bytes on the bus in the wrong order or send nonexistent upper bytes. The bench rewrites the descriptor in the middle of a sequence, which catches a design that reads live inputs instead of a captured copy. It stalls the requester and sends a stray receive strobe. A faulty design would then issue operations while the byte is held, lose or overwrite the held byte, or report data that was never requested. Chip select is checked on every handshake, so a design that drops it between phases or keeps it high while the byte is held is caught.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [1:0] LANE_SINGLE = 2'd0;
  localparam logic [1:0] LANE_DUAL   = 2'd1;
  localparam logic [1:0] LANE_QUAD   = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_PAD, ST_DATA, ST_WAIT, ST_HOLD
  } seq_st_e;

  typedef struct packed {
    logic       cmd_en;
    logic [7:0] cmd_code;
    logic [1:0] cmd_mode;
    logic [1:0] addr_mode;
    logic [7:0] pad_code;
    logic [1:0] data_mode;
    logic       oe_off;
  } seq_desc_t;
endpackage

// File: rtl/flash_lane_dec.sv
module flash_lane_dec
  import flash_seq_pkg::*;
(
  input  logic [1:0] mode_i,
  output logic [2:0] sel_o
);
  always_comb begin
    unique case (mode_i)
      LANE_DUAL: sel_o = 3'b010;
      LANE_QUAD: sel_o = 3'b100;
      default:   sel_o = 3'b001;  // single and reserved
    endcase
  end

  always_comb begin
    assert_lane_onehot_R2: assert ($countones(sel_o) == 1)
      else $error("lane select not one-hot");
  end
endmodule

// File: rtl/flash_addr_sel.sv
module flash_addr_sel #(
  parameter int AW  = 32,
  parameter int IDXW = 3
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [IDXW-1:0] idx_i,
  output logic [7:0]      byte_o
);
  localparam int NB = AW / 8;

  logic [7:0] bytes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign bytes[g] = addr_i[8*g +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (idx_i == IDXW'(i)) byte_o = bytes[i];
    end
  end
endmodule

// File: rtl/flash_rx_hold.sv
module flash_rx_hold (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_i,
  input  logic [7:0] frame_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= 8'h00;
    end else if (cap_i) begin
      valid_o <= 1'b1;
      data_o  <= frame_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_data_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o))
    else $error("held byte changed before it was taken");
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PAD_W = 6,
  localparam int AB    = AW / 8,
  localparam int ABW   = $clog2(AB + 1),
  localparam int CNT_W = (PAD_W > 4) ? PAD_W : 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cmd_en_i,
  input  logic [7:0]       cmd_code_i,
  input  logic [1:0]       cmd_mode_i,
  input  logic [ABW-1:0]   addr_bytes_i,
  input  logic [1:0]       addr_mode_i,
  input  logic [7:0]       pad_code_i,
  input  logic [PAD_W-1:0] pad_cnt_i,
  input  logic [1:0]       data_mode_i,
  input  logic             dummy_oe_off_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_addr_i,
  output logic             uop_valid_o,
  input  logic             uop_ready_i,
  output logic [7:0]       uop_frame_o,
  output logic [2:0]       uop_lane_o,
  output logic [CNT_W-1:0] uop_cnt_o,
  output logic             uop_rx_o,
  output logic             uop_oe_off_o,
  output logic             cs_o,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_frame_i,
  output logic             data_valid_o,
  input  logic             data_ready_i,
  output logic [7:0]       data_o
);
  localparam int IDXW = (AB > 1) ? $clog2(AB) : 1;

  seq_st_e          st_q;
  seq_desc_t        desc_q;
  logic [AW-1:0]    addr_q;
  logic [ABW-1:0]   nb_q;
  logic [PAD_W-1:0] pad_q;
  logic [IDXW-1:0]  idx_q;
  logic             cs_q;

  logic [ABW-1:0] nb_in;
  logic           accept, uop_fire, cap;
  logic [1:0]     lane_mode;
  logic [7:0]     addr_byte;

  assign nb_in = (addr_bytes_i > ABW'(AB)) ? ABW'(AB) : addr_bytes_i;

  function automatic seq_st_e after_cmd(logic [ABW-1:0] nb, logic [PAD_W-1:0] pc);
    if (nb != '0)      return ST_ADDR;
    else if (pc != '0) return ST_PAD;
    else               return ST_DATA;
  endfunction

  assign req_ready_o = en_i && (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign uop_valid_o = (st_q == ST_CMD) || (st_q == ST_ADDR) ||
                       (st_q == ST_PAD) || (st_q == ST_DATA);
  assign uop_fire    = uop_valid_o && uop_ready_i;
  assign cap         = (st_q == ST_WAIT) && rx_valid_i;
  assign cs_o        = cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      desc_q <= '0;
      addr_q <= '0;
      nb_q   <= '0;
      pad_q  <= '0;
      idx_q  <= '0;
      cs_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          desc_q <= '{cmd_en: cmd_en_i, cmd_code: cmd_code_i, cmd_mode: cmd_mode_i,
                      addr_mode: addr_mode_i, pad_code: pad_code_i,
                      data_mode: data_mode_i, oe_off: dummy_oe_off_i};
          addr_q <= req_addr_i;
          nb_q   <= nb_in;
          pad_q  <= pad_cnt_i;
          idx_q  <= IDXW'(nb_in - 1'b1);
          cs_q   <= 1'b1;
          st_q   <= cmd_en_i ? ST_CMD : after_cmd(nb_in, pad_cnt_i);
        end
        ST_CMD: if (uop_fire) st_q <= after_cmd(nb_q, pad_q);
        ST_ADDR: if (uop_fire) begin
          if (idx_q == '0) st_q <= (pad_q != '0) ? ST_PAD : ST_DATA;
          else             idx_q <= idx_q - 1'b1;
        end
        ST_PAD:  if (uop_fire) st_q <= ST_DATA;
        ST_DATA: if (uop_fire) st_q <= ST_WAIT;
        ST_WAIT: if (cap) begin
          st_q <= ST_HOLD;
          cs_q <= 1'b0;
        end
        ST_HOLD: if (data_valid_o && data_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_CMD:  lane_mode = desc_q.cmd_mode;
      ST_ADDR: lane_mode = desc_q.addr_mode;
      default: lane_mode = desc_q.data_mode;
    endcase
  end

  flash_lane_dec u_lane (
    .mode_i(lane_mode),
    .sel_o (uop_lane_o)
  );

  flash_addr_sel #(.AW(AW), .IDXW(IDXW)) u_addr (
    .addr_i(addr_q),
    .idx_i (idx_q),
    .byte_o(addr_byte)
  );

  always_comb begin
    unique case (st_q)
      ST_CMD:  uop_frame_o = desc_q.cmd_code;
      ST_ADDR: uop_frame_o = addr_byte;
      ST_PAD:  uop_frame_o = desc_q.pad_code;
      default: uop_frame_o = 8'h00;
    endcase
  end

  assign uop_cnt_o    = (st_q == ST_PAD) ? CNT_W'(pad_q) : CNT_W'(8);
  assign uop_rx_o     = (st_q == ST_DATA);
  assign uop_oe_off_o = (st_q == ST_PAD) && desc_q.oe_off;

  flash_rx_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .frame_i(rx_frame_i),
    .ready_i(data_ready_i),
    .valid_o(data_valid_o),
    .data_o (data_o)
  );

  assert_ready_gated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> en_i && !uop_valid_o && !data_valid_o)
    else $error("request accepted while busy or disabled");

  assert_oe_off_dummy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_oe_off_o |-> uop_valid_o && !uop_rx_o)
    else $error("output-enable suppression outside dummy phase");

  assert_rx_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_fire && uop_rx_o |=> !uop_valid_o)
    else $error("operation issued after the receive step");

  assert_cs_framing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o |-> cs_o)
    else $error("operation offered with chip select low");

  assert_cs_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> !cs_o)
    else $error("chip select high while byte held");

  assert_no_uop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> !uop_valid_o)
    else $error("operation offered while byte held");

  assert_uop_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_frame_o) &&
      $stable(uop_lane_o) && $stable(uop_cnt_o) && $stable(uop_rx_o) && $stable(uop_oe_off_o))
    else $error("operation changed while stalled");
endmodule

// File: tb/tb_flash_seq.sv
`timescale 1ns/1ps
module tb_flash_seq;
  localparam int AW = 32;
  localparam int PAD_W = 6;
  localparam int ABW = 3;
  localparam int CNT_W = 6;
  localparam int UW = 8 + 3 + CNT_W + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic en = 1'b0, cmd_en = 1'b0, oe_off = 1'b0;
  logic [7:0] cmd_code = '0, pad_code = '0;
  logic [1:0] cmd_mode = '0, addr_mode = '0, data_mode = '0;
  logic [ABW-1:0] addr_bytes = '0;
  logic [PAD_W-1:0] pad_cnt = '0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic uop_valid, uop_ready = 1'b0, uop_rx, uop_oe;
  logic [7:0] uop_frame;
  logic [2:0] uop_lane;
  logic [CNT_W-1:0] uop_cnt;
  logic cs;
  logic rx_valid, model_v = 1'b0, stray_v = 1'b0;
  logic [7:0] rx_frame, model_f = '0;
  logic data_valid, data_ready = 1'b1;
  logic [7:0] data;

  assign rx_valid = model_v | stray_v;
  assign rx_frame = stray_v ? 8'h5A : model_f;

  flash_seq #(.AW(AW), .PAD_W(PAD_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .cmd_en_i(cmd_en), .cmd_code_i(cmd_code), .cmd_mode_i(cmd_mode),
    .addr_bytes_i(addr_bytes), .addr_mode_i(addr_mode),
    .pad_code_i(pad_code), .pad_cnt_i(pad_cnt), .data_mode_i(data_mode),
    .dummy_oe_off_i(oe_off),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .uop_valid_o(uop_valid), .uop_ready_i(uop_ready), .uop_frame_o(uop_frame),
    .uop_lane_o(uop_lane), .uop_cnt_o(uop_cnt), .uop_rx_o(uop_rx),
    .uop_oe_off_o(uop_oe), .cs_o(cs),
    .rx_valid_i(rx_valid), .rx_frame_i(rx_frame),
    .data_valid_o(data_valid), .data_ready_i(data_ready), .data_o(data)
  );

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0, rx_req = 0, rx_srv = 0;
  logic [UW-1:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rx_q[$], dat_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] lane(input logic [1:0] m);  // R2 encoding
    return (m == 2'd1) ? 3'b010 : (m == 2'd2) ? 3'b100 : 3'b001;
  endfunction

  function automatic logic [UW-1:0] pk(input logic [7:0] f, input logic [2:0] l,
      input logic [CNT_W-1:0] c, input logic r, input logic o);
    return {f, l, c, r, o};
  endfunction

  task automatic do_req(input logic [AW-1:0] a, input logic [7:0] rb, input bit mangle);
    int nb;
    int target;
    target = done_cnt + 1;
    if (cmd_en) begin exp_q.push_back(pk(cmd_code, lane(cmd_mode), 8, 0, 0)); tag_q.push_back("R3"); end
    nb = (addr_bytes > 4) ? 4 : int'(addr_bytes);
    for (int k = nb - 1; k >= 0; k--) begin
      exp_q.push_back(pk(a[8*k +: 8], lane(addr_mode), 8, 0, 0)); tag_q.push_back("R4");
    end
    if (pad_cnt != 0) begin
      exp_q.push_back(pk(pad_code, lane(data_mode), CNT_W'(pad_cnt), 0, oe_off)); tag_q.push_back("R5_R6");
    end
    exp_q.push_back(pk(8'h00, lane(data_mode), 8, 1, 0)); tag_q.push_back("R7");
    rx_q.push_back(rb); dat_q.push_back(rb);
    @(posedge clk); #1 req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    if (mangle) begin  // R11: descriptor rewritten mid-sequence
      cmd_code = ~cmd_code; addr_mode = 2'd2; pad_code = 8'h00; pad_cnt = 6'd1;
      data_mode = 2'd1; oe_off = ~oe_off; addr_bytes = 3'd1;
    end
    while (done_cnt < target) @(negedge clk);
  endtask

  // shifter ready pattern
  always @(posedge clk) begin
    cyc++;
    #1 uop_ready = (cyc % 4) != 2;
  end

  // shifter receive model
  int rx_dly = 0;
  always @(posedge clk) begin
    #1;
    model_v = 1'b0;
    if (rx_srv < rx_req) begin
      if (rx_dly == 2) begin
        model_v = 1'b1; model_f = rx_q.pop_front(); rx_srv++; rx_dly = 0;
      end else rx_dly++;
    end
  end

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (uop_valid) chk(cs === 1'b1, "R8", cs, 1);
    if (uop_valid && uop_ready) begin
      if (exp_q.size() == 0) chk(0, "R7", 32'(uop_frame), 0);
      else begin
        logic [UW-1:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(pk(uop_frame, uop_lane, uop_cnt, uop_rx, uop_oe) === e, t,
            32'(pk(uop_frame, uop_lane, uop_cnt, uop_rx, uop_oe)), 32'(e));
        if (uop_rx) rx_req++;
      end
    end
    if (data_valid) begin
      chk(!uop_valid, "R9", uop_valid, 0);
      chk(cs === 1'b0, "R8", cs, 0);
      if (data_ready) begin
        logic [7:0] d;
        d = (dat_q.size() != 0) ? dat_q.pop_front() : 8'hxx;
        chk(data === d, "R9", data, d);
        done_cnt++;
      end
    end
  end

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b0 && uop_valid === 1'b0 && data_valid === 1'b0 && cs === 1'b0,
        "R1", {req_ready, uop_valid, data_valid, cs}, 0);
    // R1: disabled, request ignored
    @(posedge clk); #1 req_valid = 1'b1; req_addr = 32'h1234;
    repeat (5) begin
      @(negedge clk);
      chk(!req_ready && !uop_valid, "R1", {req_ready, uop_valid}, 0);
    end
    @(posedge clk); #1 req_valid = 1'b0; en = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", req_ready, 1);
    // R3 R4 R5 R6 R2: full sequence, mixed lanes
    cmd_en = 1; cmd_code = 8'h6B; cmd_mode = 2'd0; addr_bytes = 3; addr_mode = 2'd2;
    pad_code = 8'hA5; pad_cnt = 6; data_mode = 2'd1; oe_off = 1;
    do_req(32'hCAFE_1357, 8'h3C, 0);
    // R3 R4 R5: phases skipped
    cmd_en = 0; addr_bytes = 0; pad_cnt = 0; data_mode = 2'd2;
    do_req(32'h0000_00FF, 8'hE1, 0);
    // R4 clamp, R2 reserved mode, R6 oe kept
    cmd_en = 1; cmd_code = 8'h0B; cmd_mode = 2'd3; addr_bytes = 7; addr_mode = 2'd3;
    pad_cnt = 8; pad_code = 8'hFF; oe_off = 0; data_mode = 2'd0;
    do_req(32'h89AB_CDEF, 8'h42, 0);
    // R9: requester stalls
    data_ready = 1'b0;
    cmd_en = 0; addr_bytes = 2; addr_mode = 2'd1; pad_cnt = 0;
    fork do_req(32'h0011_2233, 8'h99, 0); join_none
    while (!data_valid) @(negedge clk);
    repeat (6) begin
      @(negedge clk);
      chk(data_valid && data === 8'h99, "R9", data, 8'h99);
    end
    @(posedge clk); #1 data_ready = 1'b1;
    wait (done_cnt == 4);
    // R12: stray strobe while idle
    @(posedge clk); #1 stray_v = 1'b1;
    @(posedge clk); #1 stray_v = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!data_valid, "R12", data_valid, 0);
    end
    // R11: descriptor rewritten after acceptance
    cmd_en = 1; cmd_code = 8'h3B; cmd_mode = 2'd1; addr_bytes = 4; addr_mode = 2'd0;
    pad_cnt = 3; pad_code = 8'h0F; data_mode = 2'd2; oe_off = 1;
    do_req(32'hDEAD_BEEF, 8'h7E, 1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && dat_q.size() == 0, "R7", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule